// File: doc/BRIEF.md
# Module Power State Controller

This block keeps a small set of peripheral modules in one of four power and clock states and moves them between states when software asks. Each module has a control word that stages the state it should go to next, together with a local reset release bit. Staged values do nothing to a module's state until software writes the command register. The controller then visits every module in ascending index order and moves each one whose staged state differs from its current state. A global busy flag and a per-module status word let software poll for completion.

Each module gets two outputs: a clock enable and an active-high reset. The clock enable is high only in the running state. The reset is high in the two reset states, and also whenever the module's local reset release bit is clear.

Software reaches the block over a plain 32-bit register bus. A write takes effect at the clock edge where it is sampled. Read data appears on the bus one cycle after the read strobe.

Top module: `pwr_state_ctl`

## Requirements
- R1: After reset every module's current state is 0, every control word reads 0 (so the local reset release bit is clear), the busy bit reads 0, every clock enable is low and every module reset is high.
- R2: The control word of module n is at byte offset 0xA00 + 4*n. Bits [1:0] hold the staged next state and bit 8 holds the local reset release (1 = released). Written values of bits [4:2], bit 9 and above, and bits 7..2 are discarded, and those bits read back as 0.
- R3: The status word of module n is at byte offset 0x800 + 4*n. Bits [4:0] report the module's current state, with bits [4:2] always 0. Writing a control word does not change this state.
- R4: A write to offset 0x120 with bit 0 set, while idle, starts a pass. Bit 0 of the word at offset 0x128 reads 1 from the next cycle until the pass ends, and 0 otherwise. A write to 0x120 with bit 0 clear has no effect.
- R5: A pass visits the modules in ascending index order. An unchanged module costs 1 cycle. A changed module costs 1 + STEP_CYC cycles, and its current state takes the staged value at the end of its own slot. A pass with C changed modules keeps busy high for N_MOD + STEP_CYC*C cycles.
- R6: A command write made while busy is high, including the pass's final cycle, is ignored: it neither restarts nor extends the pass.
- R7: State encoding is 0 = reset and clock off, 1 = synchronous reset, 2 = clock gated, 3 = running. The clock enable of module n is high only in state 3. The module reset is high in states 0 and 1, or when the release bit is 0. Both outputs follow a state or release change one cycle later.
- R8: Read data is registered and appears the cycle after the read strobe. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| mod_clk_en | output | N_MOD | Per-module clock enable |
| mod_rst | output | N_MOD | Per-module active-high reset |

## Verification
The sequencer retiring its last module and a new command write can land in the same cycle. The bench provokes this by computing the edge at which busy will fall and timing a command write to that exact edge. It first restages an already-visited module, so an accepted command would be visible. It then judges the result by three things: busy reads 0 on the following cycle, the restaged module's status still shows the old state, and the output monitor sees no change that was not predicted. A second collision is a control word written in mid-pass, after its module has been visited; it must not alter that pass.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  localparam int CMD_OFS   = 'h120;
  localparam int BUSY_OFS  = 'h128;
  localparam int STAT_BASE = 'h800;
  localparam int CTRL_BASE = 'hA00;
  localparam int REL_BIT   = 8;

  typedef enum logic [1:0] {
    PS_OFF   = 2'd0,
    PS_SRST  = 2'd1,
    PS_GATED = 2'd2,
    PS_RUN   = 2'd3
  } pstate_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_SCAN = 2'd1,
    SQ_HOLD = 2'd2
  } seq_ph_e;
endpackage

// File: rtl/pwr_regbank.sv
module pwr_regbank #(
  parameter int N_MOD  = 8,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr,
  input  logic                    rd,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [N_MOD-1:0][1:0]   cur_st,
  input  logic                    busy,
  output logic [N_MOD-1:0][1:0]   nxt_st,
  output logic [N_MOD-1:0]        rel_n,
  output logic                    go_req,
  output logic [DATA_W-1:0]       rdata
);
  import pwr_pkg::*;

  localparam int IDX_W = (N_MOD > 1) ? $clog2(N_MOD) : 1;

  logic [ADDR_W-1:0] ctrl_off, stat_off;
  logic              ctrl_in, stat_in;
  logic [IDX_W-1:0]  ctrl_idx, stat_idx;
  logic [DATA_W-1:0] rd_mux;

  // Offset decode for the two per-module windows
  always_comb begin
    ctrl_off = addr - ADDR_W'(CTRL_BASE);
    stat_off = addr - ADDR_W'(STAT_BASE);
    ctrl_idx = ctrl_off[IDX_W+1:2];
    stat_idx = stat_off[IDX_W+1:2];
    ctrl_in  = (addr[1:0] == 2'b00) && (addr >= ADDR_W'(CTRL_BASE)) &&
               (addr < ADDR_W'(CTRL_BASE + 4*N_MOD));
    stat_in  = (addr[1:0] == 2'b00) && (addr >= ADDR_W'(STAT_BASE)) &&
               (addr < ADDR_W'(STAT_BASE + 4*N_MOD));
  end

  assign go_req = wr && (addr == ADDR_W'(CMD_OFS)) && wdata[0];

  // Staged next state and local reset release per module
  always_ff @(posedge clk) begin
    if (rst) begin
      nxt_st <= '0;
      rel_n  <= '0;
    end else if (wr && ctrl_in) begin
      nxt_st[ctrl_idx] <= wdata[1:0];
      rel_n[ctrl_idx]  <= wdata[REL_BIT];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (ctrl_in) begin
      rd_mux[1:0]     = nxt_st[ctrl_idx];
      rd_mux[REL_BIT] = rel_n[ctrl_idx];
    end else if (stat_in) begin
      rd_mux[1:0] = cur_st[stat_idx];
    end else if (addr == ADDR_W'(BUSY_OFS)) begin
      rd_mux[0] = busy;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end
endmodule

// File: rtl/pwr_seq.sv
module pwr_seq #(
  parameter int N_MOD    = 8,
  parameter int STEP_CYC = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  go_req,
  input  logic [N_MOD-1:0][1:0] nxt_st,
  output logic                  busy,
  output logic [N_MOD-1:0][1:0] cur_st
);
  import pwr_pkg::*;

  localparam int IDX_W = (N_MOD > 1) ? $clog2(N_MOD) : 1;
  localparam int CNT_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_MOD - 1);

  seq_ph_e          ph;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       tgt;
  logic             at_last;

  assign at_last = (idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= SQ_IDLE;
      busy   <= 1'b0;
      idx    <= '0;
      cnt    <= '0;
      tgt    <= '0;
      cur_st <= '0;
    end else begin
      case (ph)
        SQ_IDLE: begin
          if (go_req) begin
            ph   <= SQ_SCAN;
            busy <= 1'b1;
            idx  <= '0;
          end
        end
        SQ_SCAN: begin
          if (nxt_st[idx] != cur_st[idx]) begin
            tgt <= nxt_st[idx];
            cnt <= CNT_W'(STEP_CYC - 1);
            ph  <= SQ_HOLD;
          end else if (at_last) begin
            ph   <= SQ_IDLE;
            busy <= 1'b0;
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end
        SQ_HOLD: begin
          if (cnt == '0) begin
            cur_st[idx] <= tgt;
            if (at_last) begin
              ph   <= SQ_IDLE;
              busy <= 1'b0;
            end else begin
              ph  <= SQ_SCAN;
              idx <= idx + IDX_W'(1);
            end
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: begin
          ph   <= SQ_IDLE;
          busy <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/pwr_gate_out.sv
module pwr_gate_out #(
  parameter int N_MOD = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N_MOD-1:0][1:0] cur_st,
  input  logic [N_MOD-1:0]      rel_n,
  output logic [N_MOD-1:0]      clk_en,
  output logic [N_MOD-1:0]      mod_rst
);
  import pwr_pkg::*;

  for (genvar g = 0; g < N_MOD; g++) begin : g_mod
    always_ff @(posedge clk) begin
      if (rst) begin
        clk_en[g]  <= 1'b0;
        mod_rst[g] <= 1'b1;
      end else begin
        clk_en[g]  <= (cur_st[g] == PS_RUN);
        mod_rst[g] <= (cur_st[g] == PS_OFF) || (cur_st[g] == PS_SRST) || !rel_n[g];
      end
    end
  end
endmodule

// File: rtl/pwr_state_ctl.sv
module pwr_state_ctl #(
  parameter int N_MOD    = 8,
  parameter int STEP_CYC = 4,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_MOD-1:0]  mod_clk_en,
  output logic [N_MOD-1:0]  mod_rst
);
  logic [N_MOD-1:0][1:0] nxt_st;
  logic [N_MOD-1:0][1:0] cur_st;
  logic [N_MOD-1:0]      rel_n;
  logic                  go_req;
  logic                  seq_busy;

  pwr_regbank #(.N_MOD(N_MOD), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .cur_st(cur_st), .busy(seq_busy), .nxt_st(nxt_st),
    .rel_n(rel_n), .go_req(go_req), .rdata(bus_rdata)
  );

  pwr_seq #(.N_MOD(N_MOD), .STEP_CYC(STEP_CYC)) u_seq (
    .clk(clk), .rst(rst), .go_req(go_req), .nxt_st(nxt_st),
    .busy(seq_busy), .cur_st(cur_st)
  );

  pwr_gate_out #(.N_MOD(N_MOD)) u_out (
    .clk(clk), .rst(rst), .cur_st(cur_st), .rel_n(rel_n),
    .clk_en(mod_clk_en), .mod_rst(mod_rst)
  );
endmodule

// File: rtl/pwr_state_ctl_chk.sv
module pwr_state_ctl_chk #(
  parameter int N_MOD = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  go_req,
  input logic                  busy,
  input logic [N_MOD-1:0][1:0] cur_st,
  input logic [N_MOD-1:0]      mod_clk_en
);
  logic [N_MOD-1:0][1:0] prev_st;
  logic [N_MOD-1:0]      chg;

  always_ff @(posedge clk) begin
    if (rst) prev_st <= '0;
    else     prev_st <= cur_st;
  end

  always_comb
    for (int k = 0; k < N_MOD; k++) chg[k] = (prev_st[k] != cur_st[k]);

  // R4: an accepted command raises busy on the next cycle
  a_r4_busy_rises: assert property (@(posedge clk) disable iff (rst)
    (go_req && !busy) |=> busy);

  // R6: busy only ever rises because of a command
  a_r6_rise_needs_cmd: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(go_req));

  // R5: module states only move during a pass
  a_r5_idle_stable: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(cur_st));

  // R5: at most one module changes state per cycle
  a_r5_one_at_a_time: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chg));

  for (genvar g = 0; g < N_MOD; g++) begin : g_ce
    // R7: clock enable tracks the running state one cycle later
    a_r7_clk_on: assert property (@(posedge clk) disable iff (rst)
      (cur_st[g] == 2'd3) |=> mod_clk_en[g]);
    a_r7_clk_off: assert property (@(posedge clk) disable iff (rst)
      (cur_st[g] != 2'd3) |=> !mod_clk_en[g]);
  end
endmodule

bind pwr_state_ctl pwr_state_ctl_chk #(.N_MOD(N_MOD)) u_chk (
  .clk(clk), .rst(rst), .go_req(go_req), .busy(seq_busy),
  .cur_st(cur_st), .mod_clk_en(mod_clk_en)
);

// File: tb/pwr_state_ctl_tb.sv
module pwr_state_ctl_tb;
  localparam int N    = 8;
  localparam int STEP = 4;
  localparam int AW   = 12;
  localparam int DW   = 32;

  typedef struct packed {
    logic [31:0] edge_i;
    logic [31:0] idx;
    logic        ce;
    logic        rs;
  } ev_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [N-1:0]  mod_clk_en, mod_rst;

  int   cyc = 0;
  int   n_cmp = 0, n_bad = 0;
  int   last_edge = 0;
  ev_t  exp_q[$];
  logic [1:0] m_cur [N];
  logic [1:0] m_nxt [N];
  logic       m_rel [N];
  logic [N-1:0] prev_ce, prev_rs;

  pwr_state_ctl #(.N_MOD(N), .STEP_CYC(STEP), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mod_clk_en(mod_clk_en),
    .mod_rst(mod_rst)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic f_ce(logic [1:0] s);
    return s == 2'd3;
  endfunction
  function automatic logic f_rs(logic [1:0] s, logic r);
    return (s < 2'd2) || !r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // all bus tasks enter and leave at a falling edge
  task automatic wr(input int a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(posedge clk); @(negedge clk);
    last_edge = cyc;
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = AW'(a);
    @(posedge clk); @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  // write a control word and model it, incl. the release output event
  task automatic wr_ctrl(input int n, input logic [31:0] d);
    logic nr;
    ev_t  e;
    wr('hA00 + 4*n, d);
    nr = d[8];
    m_nxt[n] = d[1:0];
    if (f_rs(m_cur[n], nr) != f_rs(m_cur[n], m_rel[n])) begin
      e.edge_i = 32'(last_edge + 1); e.idx = 32'(n);
      e.ce = f_ce(m_cur[n]); e.rs = f_rs(m_cur[n], nr);
      exp_q.push_back(e);
    end
    m_rel[n] = nr;
  endtask

  // issue a command; returns the edge at which busy must fall
  task automatic go(output int pend);
    int   c, p;
    ev_t  e;
    wr('h120, 32'h1);
    p = last_edge;
    c = 0;
    for (int k = 0; k < N; k++) begin
      if (m_nxt[k] != m_cur[k]) begin
        c++;
        if (f_ce(m_nxt[k]) != f_ce(m_cur[k]) ||
            f_rs(m_nxt[k], m_rel[k]) != f_rs(m_cur[k], m_rel[k])) begin
          e.edge_i = 32'(p + k + 1 + STEP*c + 1); e.idx = 32'(k);
          e.ce = f_ce(m_nxt[k]); e.rs = f_rs(m_nxt[k], m_rel[k]);
          exp_q.push_back(e);
        end
        m_cur[k] = m_nxt[k];
      end
    end
    pend = p + N + STEP*c;
  endtask

  task automatic wait_idle(input int pend, input string tag);
    logic [31:0] d;
    while (cyc < pend) @(negedge clk);
    rd('h128, d);
    chk({tag, " busy low after pass"}, d, 32'h0);
  endtask

  task automatic check_status(input string tag);
    logic [31:0] d;
    for (int k = 0; k < N; k++) begin
      rd('h800 + 4*k, d);
      chk($sformatf("%s status %0d", tag, k), d, {30'h0, m_cur[k]});
    end
  endtask

  // monitor: every output change must match the next expected event
  always @(negedge clk) begin
    if (!rst) begin
      for (int k = 0; k < N; k++) begin
        if (mod_clk_en[k] !== prev_ce[k] || mod_rst[k] !== prev_rs[k]) begin
          n_cmp++;
          if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R5 unexpected output change module %0d at edge %0d actual=%b%b expected=none",
                     k, cyc, mod_clk_en[k], mod_rst[k]);
          end else begin
            ev_t e;
            e = exp_q.pop_front();
            if (e.edge_i != 32'(cyc) || e.idx != 32'(k) ||
                e.ce !== mod_clk_en[k] || e.rs !== mod_rst[k]) begin
              n_bad++;
              $display("FAIL R7 event actual=edge %0d mod %0d ce %b rst %b expected=edge %0d mod %0d ce %b rst %b",
                       cyc, k, mod_clk_en[k], mod_rst[k], e.edge_i, e.idx, e.ce, e.rs);
            end
          end
        end
      end
    end
    prev_ce = mod_clk_en;
    prev_rs = mod_rst;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int pend;
    for (int k = 0; k < N; k++) begin m_cur[k] = 0; m_nxt[k] = 0; m_rel[k] = 0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 clk_en", 32'(mod_clk_en), 32'h0);
    chk("R1 mod_rst", 32'(mod_rst), 32'(8'hFF));
    rd('h128, d); chk("R1 busy", d, 32'h0);
    rd('hA0C, d); chk("R1 ctrl 3", d, 32'h0);
    check_status("R1");

    // R2 staging, masking; R3 status untouched
    wr_ctrl(2, 32'h0000_0103);
    rd('hA08, d); chk("R2 ctrl 2 readback", d, 32'h0000_0103);
    wr_ctrl(5, 32'hFFFF_FEFF);
    rd('hA14, d); chk("R2 ctrl 5 masked", d, 32'h0000_0003);
    rd('h808, d); chk("R3 status 2 before cmd", d, 32'h0);
    wr_ctrl(0, 32'h0000_0102);
    wr_ctrl(6, 32'h0000_0101);
    wr_ctrl(7, 32'h0000_0103);
    rd('h830, d); chk("R8 unmapped reads zero", d, 32'h0);

    // R4 command with bit 0 clear does nothing
    wr('h120, 32'hFFFF_FFFE);
    rd('h128, d); chk("R4 no start on bit0 clear", d, 32'h0);
    check_status("R4 after null cmd");

    // R4 R5 R7 full pass
    go(pend);
    rd('h128, d); chk("R4 busy high", d, 32'h1);
    wait_idle(pend, "R5");
    check_status("R5");

    // R7 release bit drives reset of a running module
    wr_ctrl(2, 32'h0000_0003);
    wr_ctrl(2, 32'h0000_0103);
    repeat (2) @(negedge clk);

    // R6: mid-pass command and a command on the final busy cycle
    wr_ctrl(0, 32'h0000_0103);
    wr_ctrl(4, 32'h0000_0102);
    go(pend);
    wr('h120, 32'h1);
    while (cyc < 1 + STEP + last_edge) @(negedge clk);
    wr('hA00, 32'h0000_0100);
    while (cyc < pend - 1) @(negedge clk);
    wr('h120, 32'h1);
    rd('h128, d); chk("R6 busy low after final-cycle cmd", d, 32'h0);
    rd('h800, d); chk("R6 module 0 not restarted", d, 32'h3);
    check_status("R6");
    m_nxt[0] = 2'd0;

    // apply the restaged module 0
    go(pend);
    wait_idle(pend, "R5 second");
    check_status("R5 second");

    repeat (4) @(negedge clk);
    chk("R5 all expected events seen", 32'(exp_q.size()), 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule